// File: doc/BRIEF.md
# Strobed Serial Command Transmitter

This block sits on the host side of a display driver link and serialises command and data bytes onto a three-wire bus. The strobe is active low and frames each transfer. The serial clock idles high. Data is presented while the clock is low, and the receiver takes it on the rising clock edge. Bytes arrive over a valid/ready interface together with a flag that marks the final byte of a frame. An unflagged byte keeps the strobe low, so the next byte continues the same frame.

Every bus timing minimum is a parameter counted in system clock cycles. The parameters are clock mark, clock space, data setup, data hold, strobe-to-clock spacing and strobe recovery. The block makes each bus phase exactly as long as the stricter of the limits that apply to it. The clock does not need to be periodic: while the block waits for the next byte of a frame, the clock simply stays high for longer. A busy output covers the whole frame, including the recovery time after the strobe returns high.

Top module: `strobe_serial_tx`

## Requirements
- R1: After reset and while idle: `stb_n`=1, `sclk`=1, `busy`=0, `in_ready`=1.
- R2: `sclk` is high whenever `stb_n` is high. While `stb_n` stays low, `sdo` changes only in the cycle in which `sclk` falls.
- R3: Each byte is DATA_W bits, sent least-significant bit first. The receiver samples `sdo` at each `sclk` rising edge. A frame always holds a whole number of bytes.
- R4: Each `sclk` low phase lasts exactly max(T_SPACE, T_SETUP) cycles.
- R5: Each `sclk` high phase inside a frame lasts at least max(T_MARK, T_HOLD) cycles. It lasts exactly that long unless the block is waiting for the next byte.
- R6: The first `sclk` fall of a frame comes exactly T_CLK_STB cycles after `stb_n` falls.
- R7: `stb_n` rises exactly max(T_MARK, T_HOLD) + T_CLK_STB cycles after the final `sclk` rising edge of the frame.
- R8: Between frames, `stb_n` stays high for at least T_STB_HIGH cycles.
- R9: `busy` is high whenever `stb_n` is low. After `stb_n` rises, `busy` stays high for exactly T_STB_HIGH cycles and then falls.
- R10: A frame ends after the byte accepted with `in_last`=1. After an unflagged byte, `stb_n` stays low and `sclk` stays high, for as long as it takes, until the next byte is accepted.
- R11: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while idle or while waiting between bytes of a frame, and is low whenever `sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte can be accepted this cycle |
| stb_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, valid at sclk rising edge |
| busy | output | 1 | Frame or strobe recovery in progress |

## Verification
Single-byte frames with alternating and sparse bit patterns show whether the bit order and bit alignment are correct. A three-byte frame shows that the strobe is held low across byte boundaries. All-ones and all-zeros bytes sent back to back as separate frames, with `in_valid` held high, test the recovery spacing and the exact timing of the `busy` release. One byte is followed by a long pause before the next byte of its frame. This separates the stretched clock high phase from the exact phase lengths, and also shows that the strobe is held while the block waits. A reset applied in the middle of a byte must return the bus to idle at once.

// File: rtl/strobe_tx_pkg.sv
package strobe_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_NEXT,
        ST_TRAIL,
        ST_RECOV
    } tx_state_e;

    typedef struct packed {
        tx_state_e state;
        logic      last;
    } tx_ctrl_t;

endpackage

// File: rtl/tx_phase_timer.sv
module tx_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // R4: a count in progress always moves down by one unless reloaded
    a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              bit_out,
    output logic              at_last_bit
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.data = load_data;
            sh_d.idx  = '0;
        end else if (shift) begin
            sh_d.data = {1'b0, sh_q.data[DATA_W-1:1]};
            sh_d.idx  = sh_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_out     = sh_q.data[0];
    assign at_last_bit = (sh_q.idx == LAST_IDX);

    // R3: no shift is requested past the final bit of a byte
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !at_last_bit);

endmodule

// File: rtl/strobe_serial_tx.sv
module strobe_serial_tx #(
    parameter int DATA_W     = 8,
    parameter int T_MARK     = 40,
    parameter int T_SPACE    = 40,
    parameter int T_SETUP    = 10,
    parameter int T_HOLD     = 10,
    parameter int T_CLK_STB  = 100,
    parameter int T_STB_HIGH = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              stb_n,
    output logic              sclk,
    output logic              sdo,
    output logic              busy
);

    import strobe_tx_pkg::*;

    localparam int T_LOW  = (T_SPACE > T_SETUP) ? T_SPACE : T_SETUP;
    localparam int T_HIGH = (T_MARK > T_HOLD) ? T_MARK : T_HOLD;
    localparam int T_M1   = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int T_M2   = (T_CLK_STB > T_STB_HIGH) ? T_CLK_STB : T_STB_HIGH;
    localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W  = $clog2(T_MAX) + 1;

    localparam logic [CNT_W-1:0] LV_LOW  = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] LV_HIGH = CNT_W'(T_HIGH - 1);
    localparam logic [CNT_W-1:0] LV_CS   = CNT_W'(T_CLK_STB - 1);
    localparam logic [CNT_W-1:0] LV_REC  = CNT_W'(T_STB_HIGH - 1);

    tx_ctrl_t         ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_bit;
    logic             sh_at_last;

    tx_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    tx_bit_shifter #(
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (sh_load),
        .load_data   (in_data),
        .shift       (sh_shift),
        .bit_out     (sh_bit),
        .at_last_bit (sh_at_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    ctl_d.state = ST_LEAD;
                    ctl_d.last  = in_last;
                    tmr_load    = 1'b1;
                    tmr_val     = LV_CS;
                    sh_load     = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    ctl_d.state = ST_LOW;
                    tmr_load    = 1'b1;
                    tmr_val     = LV_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    ctl_d.state = ST_HIGH;
                    tmr_load    = 1'b1;
                    tmr_val     = LV_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    if (!sh_at_last) begin
                        ctl_d.state = ST_LOW;
                        tmr_load    = 1'b1;
                        tmr_val     = LV_LOW;
                        sh_shift    = 1'b1;
                    end else if (ctl_q.last) begin
                        ctl_d.state = ST_TRAIL;
                        tmr_load    = 1'b1;
                        tmr_val     = LV_CS;
                    end else begin
                        ctl_d.state = ST_NEXT;
                    end
                end
            end
            ST_NEXT: begin
                if (in_valid) begin
                    ctl_d.state = ST_LOW;
                    ctl_d.last  = in_last;
                    tmr_load    = 1'b1;
                    tmr_val     = LV_LOW;
                    sh_load     = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (tmr_done) begin
                    ctl_d.state = ST_RECOV;
                    tmr_load    = 1'b1;
                    tmr_val     = LV_REC;
                end
            end
            ST_RECOV: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, last: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = (ctl_q.state == ST_IDLE) || (ctl_q.state == ST_NEXT);
    assign stb_n    = (ctl_q.state == ST_IDLE) || (ctl_q.state == ST_RECOV);
    assign sclk     = (ctl_q.state != ST_LOW);
    assign busy     = (ctl_q.state != ST_IDLE);
    assign sdo      = sh_bit;

    // R2: clock rests high outside a frame
    a_r2_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n |-> sclk);

    // R2: data moves only together with a falling clock inside a frame
    a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_n && !$past(stb_n) && (sdo != $past(sdo))) |-> (!sclk && $past(sclk)));

    // R9: busy covers the whole strobe-low window
    a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |-> busy);

    // R11: no byte taken while the clock is low
    a_r11_no_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> !in_ready);

    // R8: the strobe never falls straight out of a frame
    a_r8_no_fast_restrobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n) |=> stb_n);

endmodule

// File: tb/test_strobe_serial_tx.sv
module test_strobe_serial_tx;

    localparam int P_MARK   = 3;
    localparam int P_SPACE  = 2;
    localparam int P_SETUP  = 4;
    localparam int P_HOLD   = 2;
    localparam int P_CS     = 5;
    localparam int P_REC    = 6;
    localparam int EXP_LOW  = 4;
    localparam int EXP_HIGH = 3;
    localparam int N_VEC    = 9;

    // {gap after handover [12:9], last [8], data [7:0]}
    localparam logic [12:0] VEC [0:N_VEC-1] = '{
        {4'd0,  1'b1, 8'hA5},
        {4'd0,  1'b0, 8'h3C},
        {4'd0,  1'b0, 8'h01},
        {4'd0,  1'b1, 8'h80},
        {4'd0,  1'b1, 8'hFF},
        {4'd0,  1'b1, 8'h00},
        {4'd10, 1'b0, 8'h5A},
        {4'd3,  1'b1, 8'hC3},
        {4'd0,  1'b1, 8'h96}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready, stb_n, sclk, sdo, busy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    strobe_serial_tx #(
        .DATA_W     (8),
        .T_MARK     (P_MARK),
        .T_SPACE    (P_SPACE),
        .T_SETUP    (P_SETUP),
        .T_HOLD     (P_HOLD),
        .T_CLK_STB  (P_CS),
        .T_STB_HIGH (P_REC)
    ) i_strobe_serial_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .stb_n    (stb_n),
        .sclk     (sclk),
        .sdo      (sdo),
        .busy     (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bus monitor, sampled between edges
    bit         p_stb, p_sclk, p_sdo, p_busy;
    bit         in_lead, seen_frame, pending_end;
    int         lead_cnt, low_cnt, high_cnt, since_rise, stbh_cnt, busyh_cnt;
    int         bitcnt, exp_idx = 0;
    logic [7:0] cap;

    always @(negedge clk) begin
        if (!rst_n || !mon_en) begin
            p_stb = 1; p_sclk = 1; p_sdo = 0; p_busy = 0;
            in_lead = 0; seen_frame = 0; pending_end = 0;
            lead_cnt = 0; low_cnt = 0; high_cnt = 0; since_rise = 0;
            stbh_cnt = 0; busyh_cnt = 0; bitcnt = 0; cap = '0;
        end else begin
            if (!p_stb && !stb_n && (sdo != p_sdo))
                chk(p_sclk && !sclk, "R2 sdo moved off falling edge", int'(sclk), 0);
            if (p_stb && !stb_n) begin
                if (seen_frame) chk(stbh_cnt >= P_REC, "R8 strobe high time", stbh_cnt, P_REC);
                chk(busy, "R9 busy at strobe fall", int'(busy), 1);
                in_lead = 1; lead_cnt = 1;
            end else if (!p_stb && stb_n) begin
                chk(since_rise == EXP_HIGH + P_CS, "R7 last rise to strobe rise", since_rise, EXP_HIGH + P_CS);
                chk(pending_end, "R10 frame ended without last flag", int'(pending_end), 1);
                chk(bitcnt == 0, "R3 partial byte at frame end", bitcnt, 0);
                chk(sclk, "R2 clock high at strobe rise", int'(sclk), 1);
                pending_end = 0;
                stbh_cnt = 1; busyh_cnt = busy ? 1 : 0; seen_frame = 1;
            end else if (stb_n) begin
                stbh_cnt++;
                if (busy) busyh_cnt++;
            end else begin
                if (p_sclk && !sclk) begin
                    chk(!in_ready, "R11 ready while clock low", int'(in_ready), 0);
                    if (in_lead) begin
                        chk(lead_cnt == P_CS, "R6 strobe to first clock fall", lead_cnt, P_CS);
                        in_lead = 0;
                    end else begin
                        chk(high_cnt >= EXP_HIGH, "R5 clock high phase", high_cnt, EXP_HIGH);
                    end
                    low_cnt = 1;
                end else if (!sclk) begin
                    low_cnt++;
                end else if (!p_sclk && sclk) begin
                    chk(low_cnt == EXP_LOW, "R4 clock low phase", low_cnt, EXP_LOW);
                    high_cnt = 1; since_rise = 1;
                    cap = {sdo, cap[7:1]};
                    bitcnt++;
                    if (bitcnt == 8) begin
                        chk(!pending_end, "R10 byte sent after last flag", int'(pending_end), 0);
                        chk(cap == VEC[exp_idx][7:0], "R3 received byte", int'(cap), int'(VEC[exp_idx][7:0]));
                        pending_end = VEC[exp_idx][8];
                        exp_idx++;
                        bitcnt = 0;
                    end
                end else if (in_lead) begin
                    lead_cnt++;
                end else begin
                    high_cnt++; since_rise++;
                end
            end
            if (p_busy && !busy)
                chk(busyh_cnt == P_REC, "R9 busy after strobe rise", busyh_cnt, P_REC);
            p_stb = stb_n; p_sclk = sclk; p_sdo = sdo; p_busy = busy;
        end
    end

    task automatic send(input logic [12:0] v);
        in_valid = 1'b1;
        in_data  = v[7:0];
        in_last  = v[8];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (!v[8] && v[12:9] != 0) begin
            while (!in_ready) @(negedge clk);
            // R10: waiting mid-frame keeps strobe low and clock high
            chk(!stb_n && sclk, "R10 hold during mid-frame wait", int'({stb_n, sclk}), 1);
        end
        repeat (int'(v[12:9])) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(stb_n && sclk && !busy && in_ready, "R1 outputs in reset",
            int'({stb_n, sclk, busy, in_ready}), 4'b1101);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(stb_n && sclk && !busy && in_ready, "R1 idle after reset",
            int'({stb_n, sclk, busy, in_ready}), 4'b1101);

        for (int i = 0; i < N_VEC; i++) begin
            send(VEC[i]);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_idx == N_VEC, "R3 all bytes delivered", exp_idx, N_VEC);
        chk(!pending_end, "R10 final frame closed", int'(pending_end), 0);

        // R1: reset in the middle of a byte returns the bus to idle
        mon_en = 1'b0;
        in_valid = 1'b1; in_data = 8'h77; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(!stb_n, "R1 frame in progress before abort", int'(stb_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(stb_n && sclk && !busy && in_ready, "R1 idle after abort",
            int'({stb_n, sclk, busy, in_ready}), 4'b1101);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule